// File: doc/BRIEF.md
# Feature Card Configuration Handshake Controller

This block sits in one feature-card slot of a host I/O bus and decodes the four byte registers the host uses to bring the card up. Two attention strobes are made by host accesses to registers. The first comes from the ID or vector register. The second comes from the control register. A third register, the status register, resets the bring-up state. The block records which of the two attention strobes have been seen. When the second one arrives, in either order, it runs a configuration fetch through a memory master port.

The configuration fetch reads a parameter-block pointer from a fixed address. It then reads three words from that block and latches six values: the request and completion queue base addresses, the two queue sizes, the interrupt vector and the number of request queues. Once the card is configured, the strobes act as doorbells. An ID or vector access raises an express-job pulse. A control access raises a full-queue pulse. An access to an empty slot or to an offset that decodes to nothing is answered with a bus fault and sets a sticky timeout flag.

Host requests use valid/ready. The block holds `hst_ready` low while a fetch is running, and the host keeps its request stable until it is accepted. Every accepted request gets exactly one `rsp_valid` pulse. The memory master keeps `mem_req_valid` and `mem_req_addr` stable until `mem_req_ready` accepts them. It has at most one read outstanding, and it takes `mem_rsp_valid` without back-pressure.

Top module: `fcard_slot_ctrl`

## Requirements
- R1: Register offsets decode as follows: 0 is ID, 1 is vector, 2 is control and 3 is status. The handshake state has bit 0 for attention A (an ID or vector access) and bit 1 for attention B (a control access). When an access sets the second bit, in either order, a configuration fetch runs. `configured` is 1 exactly when both bits are set and no fetch is in progress.
- R2: The fetch first reads the word at `CFG_PTR_ADDR` to get the block pointer P. It then reads words at P, P+4 and P+8. The word at P is latched into `rq_base` and the word at P+4 into `cq_base`. The word at P+8 is split with the lowest address in the top byte: bits 31:24 give `rq_size`, 23:16 give `cq_size`, 15:8 give `int_vec` and 7:0 give `rq_count`.
- R3: Before configuration, and outside the trigger case of R4, a read of ID returns `board_id[15:8]` and a read of vector returns `board_id[7:0]`.
- R4: A read of ID or vector that triggers configuration, or that arrives after it, returns the latched `int_vec`. A triggering read is answered only once the fetch has finished, and it returns the newly fetched vector.
- R5: Once configured, an ID or vector access pulses `exp_job` for one cycle and a control access pulses `full_pulse` for one cycle. Both handshake bits stay set.
- R6: A status access clears the handshake state to none and pulses `card_rst` for one cycle.
- R7: An access while `board_id` is 0, or at an offset above 3, gives `rsp_fault`=1 with `rsp_data`=0, sets the sticky `tmo_flag`, and leaves the handshake state unchanged.
- R8: While a fetch runs, `hst_ready` is 0. Each accepted access gets exactly one `rsp_valid` pulse.
- R9: `seq_bit` is forced to 0 when a fetch completes. Otherwise it toggles on each cycle that `seq_flip` is 1.
- R10: A pending memory request keeps `mem_req_valid` and `mem_req_addr` unchanged until it is accepted.
- R11: Reads of control and status, and all writes, return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_id | input | 16 | Card identity; 0 means the slot is empty |
| hst_valid | input | 1 | Host access request valid |
| hst_ready | output | 1 | Block can accept a host access |
| hst_write | input | 1 | 1 for a write, 0 for a read |
| hst_offset | input | OFS_W | Register offset within the slot |
| rsp_valid | output | 1 | One-cycle response pulse per accepted access |
| rsp_data | output | 8 | Read data for the response |
| rsp_fault | output | 1 | Bus fault for the response |
| tmo_flag | output | 1 | Sticky timeout status |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Memory read word address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| rq_base | output | AW | Latched request queue base |
| cq_base | output | AW | Latched completion queue base |
| rq_size | output | 8 | Latched request queue size |
| cq_size | output | 8 | Latched completion queue size |
| int_vec | output | 8 | Latched interrupt vector |
| rq_count | output | 8 | Latched number of request queues |
| configured | output | 1 | Both handshake bits set, no fetch running |
| seq_flip | input | 1 | Card logic toggles the sequence bit |
| seq_bit | output | 1 | Completion sequence bit |
| exp_job | output | 1 | Express-job doorbell pulse |
| full_pulse | output | 1 | Full-queue doorbell pulse |
| card_rst | output | 1 | Reset request pulse to the card logic |

## Verification
Directed sequences drive the A-then-B and B-then-A orders to the trigger point. These check that either order starts the fetch. They also show whether the triggering access was a read, which must return the new vector, or a write, which must return 0. A long random mix of offsets, directions, status resets and empty-slot intervals follows. It separates the doorbell behaviour from the pre-configuration ID behaviour, and it shows whether faults disturb the handshake state. A memory model that stalls at random and answers with random latency checks the fetch addresses, the byte lanes and the rule that holds a pending request stable. Each fetch gets a new random parameter block, so stale latched values cannot match.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    RK_ID   = 3'd0,
    RK_VEC  = 3'd1,
    RK_CTRL = 3'd2,
    RK_STAT = 3'd3,
    RK_NONE = 3'd4
  } reg_kind_t;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2
  } fetch_st_t;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CFG_WORDS = 4;
  localparam logic [1:0] HS_NONE = 2'b00;
  localparam logic [1:0] HS_A    = 2'b01;
  localparam logic [1:0] HS_B    = 2'b10;
  localparam logic [1:0] HS_BOTH = 2'b11;
endpackage

// File: rtl/fcs_reg_decode.sv
module fcs_reg_decode
  import fcs_pkg::*;
#(
  parameter int unsigned OFS_W = 4
) (
  input  logic [OFS_W-1:0] offset,
  output reg_kind_t        kind
);
  always_comb begin
    kind = RK_NONE;
    if (offset < OFS_W'(4)) begin
      case (offset[1:0])
        2'd0:    kind = RK_ID;
        2'd1:    kind = RK_VEC;
        2'd2:    kind = RK_CTRL;
        default: kind = RK_STAT;
      endcase
    end
  end
endmodule

// File: rtl/fcs_cfg_fetch.sv
module fcs_cfg_fetch
  import fcs_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] CFG_PTR_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [AW-1:0]     rq_base,
  output logic [AW-1:0]     cq_base,
  output logic [7:0]        rq_size,
  output logic [7:0]        cq_size,
  output logic [7:0]        int_vec,
  output logic [7:0]        rq_count
);
  localparam int unsigned STEP_W = $clog2(CFG_WORDS);
  localparam int unsigned LANES  = WORD_W / 8;

  fetch_st_t         st_q;
  logic [STEP_W-1:0] step_q;
  logic [AW-1:0]     ptr_q;
  logic [STEP_W-1:0] step_m1;
  logic [7:0]        lane [LANES];

  // lowest byte address sits in the top lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = mem_rsp_data[WORD_W-1-8*g -: 8];
  end

  assign step_m1       = step_q - STEP_W'(1);
  assign busy          = (st_q != F_IDLE);
  assign mem_req_valid = (st_q == F_REQ);
  assign mem_req_addr  = (step_q == '0) ? CFG_PTR_ADDR
                       : ptr_q + {{(AW-STEP_W-2){1'b0}}, step_m1, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= F_IDLE;
      step_q   <= '0;
      ptr_q    <= '0;
      done     <= 1'b0;
      rq_base  <= '0;
      cq_base  <= '0;
      rq_size  <= '0;
      cq_size  <= '0;
      int_vec  <= '0;
      rq_count <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        F_IDLE: if (start) begin
          st_q   <= F_REQ;
          step_q <= '0;
        end
        F_REQ: if (mem_req_ready) st_q <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          case (step_q)
            2'd0: ptr_q   <= mem_rsp_data[AW-1:0];
            2'd1: rq_base <= mem_rsp_data[AW-1:0];
            2'd2: cq_base <= mem_rsp_data[AW-1:0];
            default: begin
              rq_size  <= lane[0];
              cq_size  <= lane[1];
              int_vec  <= lane[2];
              rq_count <= lane[3];
            end
          endcase
          if (step_q == STEP_W'(CFG_WORDS - 1)) begin
            st_q <= F_IDLE;
            done <= 1'b1;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st_q   <= F_REQ;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcard_slot_ctrl.sv
module fcard_slot_ctrl
  import fcs_pkg::*;
#(
  parameter int unsigned   AW           = 32,
  parameter int unsigned   OFS_W        = 4,
  parameter logic [AW-1:0] CFG_PTR_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       board_id,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic [OFS_W-1:0]  hst_offset,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              rsp_fault,
  output logic              tmo_flag,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [AW-1:0]     rq_base,
  output logic [AW-1:0]     cq_base,
  output logic [7:0]        rq_size,
  output logic [7:0]        cq_size,
  output logic [7:0]        int_vec,
  output logic [7:0]        rq_count,
  output logic              configured,
  input  logic              seq_flip,
  output logic              seq_bit,
  output logic              exp_job,
  output logic              full_pulse,
  output logic              card_rst
);
  reg_kind_t  kind;
  logic [1:0] hs_q;
  logic       pend_q;
  logic       pend_rd_q;
  logic       fetch_busy;
  logic       fetch_done;
  logic       accept;
  logic       slot_empty;
  logic       trig;

  fcs_reg_decode #(.OFS_W(OFS_W)) u_dec (
    .offset (hst_offset),
    .kind   (kind)
  );

  fcs_cfg_fetch #(.AW(AW), .CFG_PTR_ADDR(CFG_PTR_ADDR)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (trig),
    .busy          (fetch_busy),
    .done          (fetch_done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rq_base       (rq_base),
    .cq_base       (cq_base),
    .rq_size       (rq_size),
    .cq_size       (cq_size),
    .int_vec       (int_vec),
    .rq_count      (rq_count)
  );

  assign hst_ready  = !pend_q && !fetch_busy;
  assign accept     = hst_valid && hst_ready;
  assign slot_empty = (board_id == 16'h0000);
  assign configured = (hs_q == HS_BOTH) && !pend_q && !fetch_busy;

  always_comb begin
    trig = 1'b0;
    if (accept && !slot_empty) begin
      if ((kind == RK_ID || kind == RK_VEC) && hs_q == HS_B) trig = 1'b1;
      if (kind == RK_CTRL && hs_q == HS_A)                   trig = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q       <= HS_NONE;
      pend_q     <= 1'b0;
      pend_rd_q  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_fault  <= 1'b0;
      tmo_flag   <= 1'b0;
      seq_bit    <= 1'b0;
      exp_job    <= 1'b0;
      full_pulse <= 1'b0;
      card_rst   <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_fault  <= 1'b0;
      exp_job    <= 1'b0;
      full_pulse <= 1'b0;
      card_rst   <= 1'b0;

      if (fetch_done) seq_bit <= 1'b0;
      else if (seq_flip) seq_bit <= !seq_bit;

      if (fetch_done && pend_q) begin
        pend_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= pend_rd_q ? int_vec : 8'h00;
      end

      if (accept) begin
        if (slot_empty || kind == RK_NONE) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
          tmo_flag  <= 1'b1;
        end else if (trig) begin
          hs_q      <= HS_BOTH;
          pend_q    <= 1'b1;
          pend_rd_q <= !hst_write && (kind != RK_CTRL);
        end else begin
          rsp_valid <= 1'b1;
          case (kind)
            RK_ID, RK_VEC: begin
              if (hs_q == HS_BOTH) begin
                exp_job <= 1'b1;
                if (!hst_write) rsp_data <= int_vec;
              end else begin
                hs_q <= hs_q | HS_A;
                if (!hst_write)
                  rsp_data <= (kind == RK_ID) ? board_id[15:8] : board_id[7:0];
              end
            end
            RK_CTRL: begin
              if (hs_q == HS_BOTH) full_pulse <= 1'b1;
              else hs_q <= hs_q | HS_B;
            end
            default: begin
              hs_q     <= HS_NONE;
              card_rst <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fcs_slot_chk.sv
module fcs_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        rsp_valid,
  input logic [7:0]  rsp_data,
  input logic        rsp_fault,
  input logic        tmo_flag,
  input logic        configured,
  input logic        seq_bit,
  input logic        exp_job,
  input logic        full_pulse,
  input logic        card_rst
);
  // R8
  stall_during_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !hst_ready);

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R5
  exp_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_job |-> configured && rsp_valid);

  // R5
  full_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_pulse |-> configured && rsp_valid);

  // R6
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> !configured && rsp_valid);

  // R7
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> tmo_flag);

  // R7
  fault_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_data == 8'h00 && tmo_flag);

  // R9
  seq_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured) |-> !seq_bit);
endmodule

bind fcard_slot_ctrl fcs_slot_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hst_ready     (hst_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_data      (rsp_data),
  .rsp_fault     (rsp_fault),
  .tmo_flag      (tmo_flag),
  .configured    (configured),
  .seq_bit       (seq_bit),
  .exp_job       (exp_job),
  .full_pulse    (full_pulse),
  .card_rst      (card_rst)
);

// File: tb/tb_fcard_slot_ctrl.sv
`timescale 1ns/1ps
module tb_fcard_slot_ctrl;
  localparam logic [31:0] PTR = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] board_id = 16'h0000;
  logic        hst_valid = 1'b0;
  logic        hst_ready;
  logic        hst_write = 1'b0;
  logic [3:0]  hst_offset = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_fault;
  logic        tmo_flag;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] rq_base, cq_base;
  logic [7:0]  rq_size, cq_size, int_vec, rq_count;
  logic        configured;
  logic        seq_flip = 1'b0;
  logic        seq_bit;
  logic        exp_job, full_pulse, card_rst;

  always #2 clk = ~clk;

  fcard_slot_ctrl #(.AW(32), .OFS_W(4), .CFG_PTR_ADDR(PTR)) dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // memory contents for the current parameter block
  logic [31:0] blk_ptr, w_rq, w_cq, w_bytes;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    if (a == PTR)              return blk_ptr;
    else if (a == blk_ptr)     return w_rq;
    else if (a == blk_ptr + 4) return w_cq;
    else if (a == blk_ptr + 8) return w_bytes;
    return 32'hDEAD_BEEF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  int          lat = 0;
  logic [31:0] lat_a = '0;
  bit          held = 0;
  logic [31:0] held_a = '0;
  int          hold_bad = 0;
  int          stall_bad = 0;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      lat   <= 1 + int'($urandom % 3);
      lat_a <= mem_req_addr;
    end else if (lat != 0) lat <= lat - 1;
  end

  always @(negedge clk) begin
    if (rst_n && held && !(mem_req_valid && mem_req_addr == held_a)) hold_bad++;
    if (rst_n && mem_req_valid && hst_ready) stall_bad++;
    mem_req_ready = ($urandom % 3) != 0;
    held          = mem_req_valid && !mem_req_ready;
    held_a        = mem_req_addr;
    mem_rsp_valid = (lat == 1);
    mem_rsp_data  = mem_rsp_valid ? mem_val(lat_a) : 32'h0;
  end

  // pulse counters
  int n_exp = 0, n_full = 0, n_rst = 0;
  always @(negedge clk) begin
    if (exp_job)    n_exp++;
    if (full_pulse) n_full++;
    if (card_rst)   n_rst++;
  end

  // reference model state
  logic [1:0] hs_m = 2'b00;
  bit         tmo_m = 0;
  logic [7:0] vec_m = 8'h00;

  task automatic new_block();
    blk_ptr = 32'h0001_0000 + ($urandom & 32'h0000_FFF0);
    w_rq    = $urandom;
    w_cq    = $urandom;
    w_bytes = $urandom;
  endtask

  task automatic access(input bit wr, input logic [3:0] ofs);
    bit fault_e = 0, trig = 0;
    logic [7:0] data_e = 8'h00;
    int e_exp = n_exp, e_full = n_full, e_rst = n_rst;
    int guard;
    if (board_id == 16'h0 || ofs > 4'd3) begin
      fault_e = 1; tmo_m = 1;
    end else begin
      case (ofs)
        4'd0, 4'd1: begin
          if (hs_m == 2'b10) begin
            trig = 1; new_block(); vec_m = w_bytes[15:8]; hs_m = 2'b11;
            if (!wr) data_e = vec_m;
          end else if (hs_m == 2'b11) begin
            e_exp++; if (!wr) data_e = vec_m;
          end else begin
            hs_m = hs_m | 2'b01;
            if (!wr) data_e = (ofs == 4'd0) ? board_id[15:8] : board_id[7:0];
          end
        end
        4'd2: begin
          if (hs_m == 2'b01) begin
            trig = 1; new_block(); vec_m = w_bytes[15:8]; hs_m = 2'b11;
          end else if (hs_m == 2'b11) e_full++;
          else hs_m = hs_m | 2'b10;
        end
        default: begin
          e_rst++; hs_m = 2'b00;
        end
      endcase
    end
    @(negedge clk);
    hst_valid = 1; hst_write = wr; hst_offset = ofs;
    guard = 0;
    while (!hst_ready && guard < 200) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    hst_valid = 0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    chk(rsp_valid, "R8 response", rsp_valid, 1);
    chk(rsp_fault == fault_e, "R7 fault", rsp_fault, fault_e);
    if (trig && !wr) chk(rsp_data == data_e, "R4 trigger read", rsp_data, data_e);
    else if (ofs <= 4'd1 && hs_m == 2'b11 && !fault_e)
      chk(rsp_data == data_e, "R4 vector read", rsp_data, data_e);
    else if (ofs <= 4'd1 && !fault_e)
      chk(rsp_data == data_e, "R3 id read", rsp_data, data_e);
    else chk(rsp_data == data_e, "R11 zero data", rsp_data, data_e);
    chk(configured == (hs_m == 2'b11), "R1 configured", configured, hs_m == 2'b11);
    chk(tmo_flag == tmo_m, "R7 tmo flag", tmo_flag, tmo_m);
    if (trig) begin
      chk(rq_base == w_rq, "R2 rq_base", rq_base, w_rq);
      chk(cq_base == w_cq, "R2 cq_base", cq_base, w_cq);
      chk({rq_size, cq_size, int_vec, rq_count} == w_bytes, "R2 byte lanes",
          {rq_size, cq_size, int_vec, rq_count}, w_bytes);
      chk(seq_bit == 1'b0, "R9 seq cleared", seq_bit, 0);
    end
    @(negedge clk);
    chk(n_exp == e_exp, "R5 exp_job count", n_exp, e_exp);
    chk(n_full == e_full, "R5 full_pulse count", n_full, e_full);
    chk(n_rst == e_rst, "R6 card_rst count", n_rst, e_rst);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    new_block();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hst_ready && !rsp_valid && !configured && !tmo_flag && !mem_req_valid && !seq_bit,
        "R1 reset state", {hst_ready, rsp_valid, configured, tmo_flag, mem_req_valid, seq_bit}, 6'b100000);

    board_id = 16'hA53C;
    // R3: ID bytes before configuration, A then B order
    access(0, 4'd0);
    access(0, 4'd1);
    access(1, 4'd2);            // R1 triggers from A then B
    // R9: sequence bit toggles outside a fetch
    @(negedge clk); seq_flip = 1;
    @(negedge clk); seq_flip = 0;
    chk(seq_bit == 1'b1, "R9 seq toggle", seq_bit, 1);
    access(0, 4'd0);            // R5 express job, R4 vector read
    access(0, 4'd2);            // R5 full pulse
    access(0, 4'd3);            // R6 reset
    // B then A order with a triggering read
    access(0, 4'd2);
    access(0, 4'd1);            // R4 triggering read returns new vector
    // R7 undecoded offset and empty slot leave state alone
    access(0, 4'd9);
    board_id = 16'h0000;
    access(0, 4'd3);
    board_id = 16'h1E07;
    access(1, 4'd1);            // still configured: express job

    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 20);
      logic [3:0] o;
      board_id = (r == 0) ? 16'h0000 : 16'h1E07;
      r = int'($urandom % 16);
      o = (r < 4) ? 4'd0 : (r < 8) ? 4'd1 : (r < 12) ? 4'd2 : (r < 14) ? 4'd3 : 4'(4 + $urandom % 12);
      access(1'($urandom % 2), o);
    end

    chk(hold_bad == 0, "R10 request hold", hold_bad, 0);
    chk(stall_bad == 0, "R8 host stall", stall_bad, 0);
    finish_run();
  end
endmodule